// File: doc/BRIEF.md
# Tagged Memory Command Slave Port

This block sits between a processing core and an external memory controller. The core queues write commands and read commands. A write command holds an address, a data word and a tag, and a read command holds an address and a tag. Each kind goes into its own queue. The memory controller acts as master. It sees a request line, takes the command at the head of a queue by pulsing an acknowledge, and may take the next command on the following clock. The write path and the read path are fully separate, so commands of both kinds can be outstanding at once.

Completions do not come back in order. They are matched by tag. The controller reports a finished write by returning its tag with a strobe. It returns read data together with the read tag under a data-valid strobe. The block keeps a table of the tags it has issued and not yet seen returned. A return that matches an entry frees that entry and is passed to the core one cycle later on valid-qualified outputs. A return that matches no entry is dropped and sets a sticky error flag. Each queue also shows its fill count and an almost-empty flag, which the controller can use to plan its accesses. A pending-read limit sizes the table of outstanding reads. When that table is full, the core cannot queue further reads.

Top module: `mem_cmd_port`

## Requirements
- R1: A write command is accepted on a clock where `wr_cmd_valid` and `wr_cmd_ready` are both high. `mc_wr_addr`, `mc_wr_data` and `mc_wr_tag` show the oldest accepted write that has not been acknowledged, so commands leave in the order they arrived.
- R2: `mc_wr_req` is high while at least one write is queued and the write tag table has a free entry. An `mc_wr_ack` on a clock where `mc_wr_req` is high removes the head, and the next queued command is visible right after that edge. An acknowledge while `mc_wr_req` is low has no effect.
- R3: The read queue behaves like the write queue, using `rd_cmd_*`, `mc_rd_req`, `mc_rd_ack`, `mc_rd_addr` and `mc_rd_tag`. Write and read commands can be accepted and acknowledged on the same clock without affecting each other.
- R4: `mc_wr_count` and `mc_rd_count` equal the number of commands queued in each queue. Each almost-empty output is high exactly when its count is 1.
- R5: When a queue holds `FIFO_DEPTH` commands, its ready output is low and a command offered on that clock is dropped. While `MAX_WR_PEND` writes are acknowledged and not yet completed, `mc_wr_req` stays low even if writes are queued.
- R6: Acknowledging a read adds one outstanding read, and a matched data-valid removes one. While `MAX_RD_PEND` reads are outstanding, `rd_cmd_ready` and `mc_rd_req` are low.
- R7: An `mc_wr_done_valid` whose `mc_wr_done_tag` matches an outstanding write produces `wr_done_valid` with the same tag on the next clock and frees that write's entry.
- R8: An `mc_rd_data_valid` whose tag matches an outstanding read produces `rd_resp_valid` with the same data and tag on the next clock. `mc_rd_data_tag` is ignored while `mc_rd_data_valid` is low.
- R9: A write completion or read return whose tag matches no outstanding entry produces no response and sets `ret_error`. `ret_error` stays high until reset.
- R10: After reset both queues are empty, both counts are 0, the request, almost-empty and response-valid outputs are low, both ready outputs are high, and `ret_error` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_cmd_valid | input | 1 | Core offers a write command |
| wr_cmd_ready | output | 1 | Write queue can accept a command |
| wr_cmd_addr | input | ADDR_W | Write address |
| wr_cmd_data | input | DATA_W | Write data |
| wr_cmd_tag | input | WTAG_W | Write tag |
| rd_cmd_valid | input | 1 | Core offers a read command |
| rd_cmd_ready | output | 1 | Read queue can accept a command |
| rd_cmd_addr | input | ADDR_W | Read address |
| rd_cmd_tag | input | RTAG_W | Read tag |
| wr_done_valid | output | 1 | Matched write completion strobe |
| wr_done_tag | output | WTAG_W | Tag of the completed write |
| rd_resp_valid | output | 1 | Matched read return strobe |
| rd_resp_data | output | DATA_W | Returned read data |
| rd_resp_tag | output | RTAG_W | Tag of the returned read |
| ret_error | output | 1 | Sticky unmatched-return flag |
| mc_wr_req | output | 1 | A write is ready for the controller |
| mc_wr_ack | input | 1 | Controller takes the head write |
| mc_wr_addr | output | ADDR_W | Head write address |
| mc_wr_data | output | DATA_W | Head write data |
| mc_wr_tag | output | WTAG_W | Head write tag |
| mc_wr_count | output | $clog2(FIFO_DEPTH+1) | Queued write count |
| mc_wr_almost_empty | output | 1 | Exactly one write queued |
| mc_rd_req | output | 1 | A read is ready for the controller |
| mc_rd_ack | input | 1 | Controller takes the head read |
| mc_rd_addr | output | ADDR_W | Head read address |
| mc_rd_tag | output | RTAG_W | Head read tag |
| mc_rd_count | output | $clog2(FIFO_DEPTH+1) | Queued read count |
| mc_rd_almost_empty | output | 1 | Exactly one read queued |
| mc_wr_done_valid | input | 1 | Controller reports a finished write |
| mc_wr_done_tag | input | WTAG_W | Tag of the finished write |
| mc_rd_data_valid | input | 1 | Controller returns read data |
| mc_rd_data | input | DATA_W | Returned data |
| mc_rd_data_tag | input | RTAG_W | Tag of the returned data |

## Verification
The tag-table assertions assume that the controller acknowledges only while the matching request is high. The RTL enforces this by gating each acknowledge with its request, so a table can never be asked to hold more entries than it has. The response assertions assume the controller returns each tag once. The bench returns only tags it has seen acknowledged, except in one deliberate unmatched return, which it saves for the end because the error flag is sticky. All tags outstanding at any one time are kept distinct, so each return identifies exactly one entry.

// File: rtl/mcp_pkg.sv
package mcp_pkg;
  // Width of a counter that must reach n inclusive
  function automatic int cnt_w(input int n);
    return $clog2(n + 1);
  endfunction
  // Width of an index into n slots (at least one bit)
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mcp_cmd_fifo.sv
module mcp_cmd_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PTR_W = mcp_pkg::idx_w(DEPTH),
  localparam int CNT_W = mcp_pkg::cnt_w(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             almost_empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_n, rptr_q, rptr_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             push_ok, pop_ok;

  assign full         = (cnt_q == CNT_W'(DEPTH));
  assign empty        = (cnt_q == '0);
  assign almost_empty = (cnt_q == CNT_W'(1));
  assign count        = cnt_q;
  assign dout         = mem[rptr_q];
  assign push_ok      = push && !full;
  assign pop_ok       = pop && !empty;

  always_comb begin
    wptr_n = wptr_q;
    rptr_n = rptr_q;
    cnt_n  = cnt_q;
    if (push_ok) wptr_n = (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (pop_ok)  rptr_n = (rptr_q == PTR_W'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    if (push_ok && !pop_ok) cnt_n = cnt_q + 1'b1;
    if (pop_ok && !push_ok) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      cnt_q  <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= din;
  end

  // R4: an accepted push without a pop raises the count by one
  a_r4_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !(pop && !empty)) |=> (count == $past(count) + 1'b1));
  // R4: taking the second-last entry leaves the almost-empty flag set
  a_r4_almost_empty_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(2) && pop && !push) |=> almost_empty);
  // R5: a push into a full queue leaves the count unchanged unless a pop happens
  a_r5_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (count == CNT_W'(DEPTH)));
endmodule

// File: rtl/mcp_tag_tracker.sv
module mcp_tag_tracker #(
  parameter int TAG_W = 4,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insert,
  input  logic [TAG_W-1:0] ins_tag,
  input  logic             release_v,
  input  logic [TAG_W-1:0] rel_tag,
  output logic             hit,
  output logic             full
);
  localparam int IDX_W = mcp_pkg::idx_w(DEPTH);
  localparam int CNT_W = mcp_pkg::cnt_w(DEPTH);

  logic [DEPTH-1:0] vld_q, vld_n;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [TAG_W-1:0] tag_n [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [IDX_W-1:0] hit_idx, free_idx;
  logic             free_found;

  assign full = (cnt_q == CNT_W'(DEPTH));

  // lowest free slot and lowest live slot holding the returned tag
  always_comb begin
    hit        = 1'b0;
    hit_idx    = '0;
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!hit && vld_q[i] && tag_q[i] == rel_tag) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (!free_found && !vld_q[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    vld_n = vld_q;
    tag_n = tag_q;
    cnt_n = cnt_q;
    if (release_v && hit) begin
      vld_n[hit_idx] = 1'b0;
      cnt_n          = cnt_n - 1'b1;
    end
    if (insert && !full) begin
      vld_n[free_idx] = 1'b1;
      tag_n[free_idx] = ins_tag;
      cnt_n           = cnt_n + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      cnt_q <= '0;
    end else begin
      vld_q <= vld_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    tag_q <= tag_n;
  end

  // R6: the owner never inserts into a full table
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    insert |-> !full);
  // R6: occupancy count agrees with the live slot flags
  a_r6_count_matches_slots: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld_q) == int'(cnt_q));
endmodule

// File: rtl/mem_cmd_port.sv
module mem_cmd_port #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int WTAG_W      = 4,   // at least 4
  parameter int RTAG_W      = 8,   // at least 8
  parameter int FIFO_DEPTH  = 4,   // power of two
  parameter int MAX_WR_PEND = 4,
  parameter int MAX_RD_PEND = 4,
  localparam int CNT_W = mcp_pkg::cnt_w(FIFO_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd_valid,
  output logic              wr_cmd_ready,
  input  logic [ADDR_W-1:0] wr_cmd_addr,
  input  logic [DATA_W-1:0] wr_cmd_data,
  input  logic [WTAG_W-1:0] wr_cmd_tag,
  input  logic              rd_cmd_valid,
  output logic              rd_cmd_ready,
  input  logic [ADDR_W-1:0] rd_cmd_addr,
  input  logic [RTAG_W-1:0] rd_cmd_tag,
  output logic              wr_done_valid,
  output logic [WTAG_W-1:0] wr_done_tag,
  output logic              rd_resp_valid,
  output logic [DATA_W-1:0] rd_resp_data,
  output logic [RTAG_W-1:0] rd_resp_tag,
  output logic              ret_error,
  output logic              mc_wr_req,
  input  logic              mc_wr_ack,
  output logic [ADDR_W-1:0] mc_wr_addr,
  output logic [DATA_W-1:0] mc_wr_data,
  output logic [WTAG_W-1:0] mc_wr_tag,
  output logic [CNT_W-1:0]  mc_wr_count,
  output logic              mc_wr_almost_empty,
  output logic              mc_rd_req,
  input  logic              mc_rd_ack,
  output logic [ADDR_W-1:0] mc_rd_addr,
  output logic [RTAG_W-1:0] mc_rd_tag,
  output logic [CNT_W-1:0]  mc_rd_count,
  output logic              mc_rd_almost_empty,
  input  logic              mc_wr_done_valid,
  input  logic [WTAG_W-1:0] mc_wr_done_tag,
  input  logic              mc_rd_data_valid,
  input  logic [DATA_W-1:0] mc_rd_data,
  input  logic [RTAG_W-1:0] mc_rd_data_tag
);
  localparam int WQ_W = ADDR_W + DATA_W + WTAG_W;
  localparam int RQ_W = ADDR_W + RTAG_W;

  logic            wq_full, wq_empty, rq_full, rq_empty;
  logic            wr_push, wr_pop, rd_push, rd_pop;
  logic            wt_hit, wt_full, rt_hit, rt_full;
  logic [WQ_W-1:0] wq_head;
  logic [RQ_W-1:0] rq_head;

  // response registers: next-state and state
  logic              wdv_n, wdv_q, rrv_n, rrv_q, err_n, err_q;
  logic [WTAG_W-1:0] wdt_n, wdt_q;
  logic [DATA_W-1:0] rrd_n, rrd_q;
  logic [RTAG_W-1:0] rrt_n, rrt_q;

  assign wr_cmd_ready = !wq_full;
  assign rd_cmd_ready = !rq_full && !rt_full;
  assign wr_push      = wr_cmd_valid && wr_cmd_ready;
  assign rd_push      = rd_cmd_valid && rd_cmd_ready;
  assign mc_wr_req    = !wq_empty && !wt_full;
  assign mc_rd_req    = !rq_empty && !rt_full;
  assign wr_pop       = mc_wr_ack && mc_wr_req;
  assign rd_pop       = mc_rd_ack && mc_rd_req;

  assign {mc_wr_addr, mc_wr_data, mc_wr_tag} = wq_head;
  assign {mc_rd_addr, mc_rd_tag}             = rq_head;

  mcp_cmd_fifo #(.W(WQ_W), .DEPTH(FIFO_DEPTH)) u_wq (
    .clk(clk), .rst_n(rst_n), .push(wr_push),
    .din({wr_cmd_addr, wr_cmd_data, wr_cmd_tag}), .pop(wr_pop),
    .dout(wq_head), .count(mc_wr_count), .full(wq_full), .empty(wq_empty),
    .almost_empty(mc_wr_almost_empty));

  mcp_cmd_fifo #(.W(RQ_W), .DEPTH(FIFO_DEPTH)) u_rq (
    .clk(clk), .rst_n(rst_n), .push(rd_push),
    .din({rd_cmd_addr, rd_cmd_tag}), .pop(rd_pop),
    .dout(rq_head), .count(mc_rd_count), .full(rq_full), .empty(rq_empty),
    .almost_empty(mc_rd_almost_empty));

  mcp_tag_tracker #(.TAG_W(WTAG_W), .DEPTH(MAX_WR_PEND)) u_wtrk (
    .clk(clk), .rst_n(rst_n), .insert(wr_pop), .ins_tag(mc_wr_tag),
    .release_v(mc_wr_done_valid), .rel_tag(mc_wr_done_tag),
    .hit(wt_hit), .full(wt_full));

  mcp_tag_tracker #(.TAG_W(RTAG_W), .DEPTH(MAX_RD_PEND)) u_rtrk (
    .clk(clk), .rst_n(rst_n), .insert(rd_pop), .ins_tag(mc_rd_tag),
    .release_v(mc_rd_data_valid), .rel_tag(mc_rd_data_tag),
    .hit(rt_hit), .full(rt_full));

  always_comb begin
    wdv_n = mc_wr_done_valid && wt_hit;
    wdt_n = wdt_q;
    if (wdv_n) wdt_n = mc_wr_done_tag;
    rrv_n = mc_rd_data_valid && rt_hit;
    rrd_n = rrd_q;
    rrt_n = rrt_q;
    if (rrv_n) begin
      rrd_n = mc_rd_data;
      rrt_n = mc_rd_data_tag;
    end
    err_n = err_q || (mc_wr_done_valid && !wt_hit) || (mc_rd_data_valid && !rt_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdv_q <= 1'b0;
      wdt_q <= '0;
      rrv_q <= 1'b0;
      rrd_q <= '0;
      rrt_q <= '0;
      err_q <= 1'b0;
    end else begin
      wdv_q <= wdv_n;
      wdt_q <= wdt_n;
      rrv_q <= rrv_n;
      rrd_q <= rrd_n;
      rrt_q <= rrt_n;
      err_q <= err_n;
    end
  end

  assign wr_done_valid = wdv_q;
  assign wr_done_tag   = wdt_q;
  assign rd_resp_valid = rrv_q;
  assign rd_resp_data  = rrd_q;
  assign rd_resp_tag   = rrt_q;
  assign ret_error     = err_q;

  // R2: no write request with an empty write queue
  a_r2_req_needs_queue: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_wr_count == '0) |-> !mc_wr_req);
  // R7: a write completion output always follows a controller strobe
  a_r7_done_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done_valid |-> $past(mc_wr_done_valid));
  // R8: a read response always follows a data-valid strobe with the same data
  a_r8_resp_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_resp_valid |-> ($past(mc_rd_data_valid) && rd_resp_data == $past(mc_rd_data)));
  // R9: the error flag never clears outside reset
  a_r9_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ret_error |=> ret_error);
  // R6: no read request while the outstanding-read table is full
  a_r6_read_limit: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cmd_ready && !rq_full |-> !mc_rd_req);
endmodule

// File: tb/tb_mem_cmd_port.sv
module tb_mem_cmd_port;
  localparam int AW = 8, DW = 16, WTW = 4, RTW = 8, FD = 4, CW = 3;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;  // 125 MHz

  logic           wv, rv, wack, rack, dv_w, dv_r;
  logic [AW-1:0]  waddr, raddr;
  logic [DW-1:0]  wdata, rdat;
  logic [WTW-1:0] wtag, dtag_w;
  logic [RTW-1:0] rtag, dtag_r;

  logic           wr_cmd_ready, rd_cmd_ready, wr_done_valid, rd_resp_valid, ret_error;
  logic [WTW-1:0] wr_done_tag, mc_wr_tag;
  logic [DW-1:0]  rd_resp_data, mc_wr_data;
  logic [RTW-1:0] rd_resp_tag, mc_rd_tag;
  logic           mc_wr_req, mc_rd_req, mc_wr_ae, mc_rd_ae;
  logic [AW-1:0]  mc_wr_addr, mc_rd_addr;
  logic [CW-1:0]  mc_wr_count, mc_rd_count;

  mem_cmd_port dut (
    .clk(clk), .rst_n(rst_n),
    .wr_cmd_valid(wv), .wr_cmd_ready(wr_cmd_ready), .wr_cmd_addr(waddr),
    .wr_cmd_data(wdata), .wr_cmd_tag(wtag),
    .rd_cmd_valid(rv), .rd_cmd_ready(rd_cmd_ready), .rd_cmd_addr(raddr), .rd_cmd_tag(rtag),
    .wr_done_valid(wr_done_valid), .wr_done_tag(wr_done_tag),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data), .rd_resp_tag(rd_resp_tag),
    .ret_error(ret_error),
    .mc_wr_req(mc_wr_req), .mc_wr_ack(wack), .mc_wr_addr(mc_wr_addr), .mc_wr_data(mc_wr_data),
    .mc_wr_tag(mc_wr_tag), .mc_wr_count(mc_wr_count), .mc_wr_almost_empty(mc_wr_ae),
    .mc_rd_req(mc_rd_req), .mc_rd_ack(rack), .mc_rd_addr(mc_rd_addr), .mc_rd_tag(mc_rd_tag),
    .mc_rd_count(mc_rd_count), .mc_rd_almost_empty(mc_rd_ae),
    .mc_wr_done_valid(dv_w), .mc_wr_done_tag(dtag_w),
    .mc_rd_data_valid(dv_r), .mc_rd_data(rdat), .mc_rd_data_tag(dtag_r));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  function automatic logic [DW-1:0] rdval(input int t);
    return DW'(t * 37 + 5);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0;
    {wv, rv, wack, rack, dv_w, dv_r} = '0;
    waddr = '0; raddr = '0; wdata = '0; rdat = '0;
    wtag = '0; dtag_w = '0; rtag = '0; dtag_r = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R10 reset state
    chk("R10 wr count", mc_wr_count, 0);
    chk("R10 rd count", mc_rd_count, 0);
    chk("R10 reqs", {mc_wr_req, mc_rd_req, mc_wr_ae, mc_rd_ae}, 0);
    chk("R10 readys", {wr_cmd_ready, rd_cmd_ready}, 2'b11);
    chk("R10 valids/error", {wr_done_valid, rd_resp_valid, ret_error}, 0);

    // R2 acknowledge while idle is ignored
    wack = 1; rack = 1; step(); wack = 0; rack = 0;
    chk("R2 idle ack wr count", mc_wr_count, 0);
    chk("R3 idle ack rd count", mc_rd_count, 0);

    // R1 R2 R4 R7 sweep over every fill level
    for (int n = 1; n <= FD; n++) begin
      for (int i = 0; i < n; i++) begin
        wv = 1; waddr = AW'(n * 16 + i); wdata = DW'(n * 4096 + i * 257); wtag = WTW'(i);
        step(); wv = 0;
        chk("R4 wr count", mc_wr_count, i + 1);
        chk("R4 wr almost empty", mc_wr_ae, (i == 0));
      end
      for (int i = 0; i < n; i++) begin
        chk("R2 wr req", mc_wr_req, 1);
        chk("R1 head addr", mc_wr_addr, n * 16 + i);
        chk("R1 head data", mc_wr_data, DW'(n * 4096 + i * 257));
        chk("R1 head tag", mc_wr_tag, i);
        wack = 1; step(); wack = 0;
        chk("R2 wr count after ack", mc_wr_count, n - 1 - i);
      end
      chk("R2 wr req drops", mc_wr_req, 0);
      for (int i = n - 1; i >= 0; i--) begin
        dv_w = 1; dtag_w = WTW'(i); step(); dv_w = 0;
        chk("R7 done valid", wr_done_valid, 1);
        chk("R7 done tag", wr_done_tag, i);
      end
      step();
      chk("R7 done one cycle", wr_done_valid, 0);
    end

    // R5 queue full drops extra write
    for (int i = 0; i <= FD; i++) begin
      wv = 1; waddr = AW'(200 + i); wdata = DW'(i); wtag = WTW'(8 + i);
      step();
    end
    wv = 0;
    chk("R5 wr ready low when full", wr_cmd_ready, 0);
    chk("R5 wr count capped", mc_wr_count, FD);
    for (int i = 0; i < FD; i++) begin
      chk("R5 surviving tag", mc_wr_tag, 8 + i);
      wack = 1; step(); wack = 0;
      dv_w = 1; dtag_w = WTW'(8 + i); step(); dv_w = 0;
    end
    chk("R5 drained", mc_wr_count, 0);

    // R5 write table full blocks the request
    for (int i = 0; i <= FD; i++) begin
      wv = 1; wtag = WTW'(i); step(); wv = 0;
      if (i < FD) begin wack = 1; step(); wack = 0; end
    end
    chk("R5 wr queued", mc_wr_count, 1);
    chk("R5 wr req blocked by table", mc_wr_req, 0);
    dv_w = 1; dtag_w = WTW'(0); step(); dv_w = 0;
    chk("R5 wr req after completion", mc_wr_req, 1);
    wack = 1; step(); wack = 0;
    for (int i = 1; i <= FD; i++) begin
      dv_w = 1; dtag_w = WTW'(i); step(); dv_w = 0;
      chk("R7 drain tag", wr_done_tag, i);
    end

    // R3 R6 read path with limit
    for (int i = 0; i < FD; i++) begin
      rv = 1; raddr = AW'(100 + i); rtag = RTW'(8'hA0 + i); step(); rv = 0;
      chk("R4 rd count", mc_rd_count, i + 1);
      chk("R4 rd almost empty", mc_rd_ae, (i == 0));
    end
    for (int i = 0; i < FD; i++) begin
      chk("R3 rd head addr", mc_rd_addr, 100 + i);
      chk("R3 rd head tag", mc_rd_tag, 8'hA0 + i);
      rack = 1; step(); rack = 0;
    end
    chk("R6 rd ready low at limit", rd_cmd_ready, 0);
    // R8 tag ignored without strobe
    dtag_r = 8'hA1; step(); step();
    chk("R8 no resp without strobe", rd_resp_valid, 0);
    chk("R8 still at limit", rd_cmd_ready, 0);
    begin
      int order [4] = '{2, 0, 3, 1};
      for (int k = 0; k < 4; k++) begin
        dv_r = 1; dtag_r = RTW'(8'hA0 + order[k]); rdat = rdval(order[k]); step(); dv_r = 0;
        chk("R8 resp valid", rd_resp_valid, 1);
        chk("R8 resp tag", rd_resp_tag, 8'hA0 + order[k]);
        chk("R8 resp data", rd_resp_data, rdval(order[k]));
        chk("R6 rd ready after return", rd_cmd_ready, 1);
      end
    end

    // R3 simultaneous write and read
    wv = 1; wtag = 4'h5; waddr = 8'h11; rv = 1; rtag = 8'h33; raddr = 8'h22;
    step(); wv = 0; rv = 0;
    chk("R3 both counts", {mc_wr_count, mc_rd_count}, {3'd1, 3'd1});
    wack = 1; rack = 1; step(); wack = 0; rack = 0;
    chk("R3 both drained", {mc_wr_count, mc_rd_count}, 0);
    dv_w = 1; dtag_w = 4'h5; dv_r = 1; dtag_r = 8'h33; rdat = 16'hBEEF; step();
    dv_w = 0; dv_r = 0;
    chk("R3 both responses", {wr_done_valid, rd_resp_valid}, 2'b11);
    chk("R3 read data", rd_resp_data, 16'hBEEF);
    chk("R9 no error yet", ret_error, 0);

    // R9 unmatched return
    dv_r = 1; dtag_r = 8'h55; step(); dv_r = 0;
    chk("R9 no resp for stray tag", rd_resp_valid, 0);
    chk("R9 error set", ret_error, 1);
    step(); step();
    chk("R9 error sticky", ret_error, 1);

    finished = 1;
    summary();
  end
endmodule